// File: doc/BRIEF.md
# Transmit Frame-Sync Generator

This block decides where a serial transmitter's frame-sync comes from, and it builds the internal sync sources. It runs on the system clock. A one-cycle bit-clock enable strobe marks each bit-clock period, and every internal timing step happens only on a cycle where that strobe is high.

The block has two internal sync sources:
- A periodic pulse train. The period and the pulse width are both programmable.
- A one-shot pulse. It fires after the transmit holding register has been copied into the shift register.

A selector sends one of three sources to the transmitter: the external sync pin, the one-shot pulse, or the periodic train. The periodic train is also brought out on a port of its own, so other logic can use it.

Period and width changes are sampled only at a period boundary. A reprogrammed value therefore never produces a cut-short or stretched frame.

Top module: `txfs_gen`

## Requirements
- R1: When `int_sync_en` is 0, `txsync_o` equals `ext_sync_i` in the same cycle, whatever the internal sources are doing.
- R2: When `int_sync_en` is 1 and `periodic_mode` is 0, a copy event makes `txsync_o` go high at the next bit-clock enable. If the event and an enable share a cycle, that enable counts as the next one. `txsync_o` then stays high for exactly one bit-clock period and is low otherwise.
- R3: When `int_sync_en` is 1 and `periodic_mode` is 1, `txsync_o` equals `pulse_o`.
- R4: The periodic pulse repeats every `period_m1`+1 bit-clock enables. `period_m1` is 12 bits, so the period ranges from 1 to 4096.
- R5: In each period, `pulse_o` is high for the first `width_m1`+1 bit-clock periods and low for the rest. `width_m1` is 8 bits.
- R6: When `width_m1` is greater than or equal to `period_m1`, `pulse_o` stays high for the whole period.
- R7: `pulse_o` and the one-shot pulse change only in the cycle after a bit-clock enable. Between enables they hold their value.
- R8: Synchronous reset drives `pulse_o` low and clears the pending one-shot. The first periodic pulse begins at the first bit-clock enable after reset is released.
- R9: A new `period_m1` or `width_m1` is applied only when a new period starts. The period already under way finishes with the old values.
- R10: Several copy events before one bit-clock enable produce a single one-bit-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Bit-clock enable strobe, one cycle wide |
| int_sync_en | input | 1 | 1 selects an internal sync source, 0 selects the pin |
| periodic_mode | input | 1 | With internal sync: 1 selects the periodic train, 0 selects the copy one-shot |
| period_m1 | input | 12 | Period length minus one, in bit-clock periods |
| width_m1 | input | 8 | Pulse width minus one, in bit-clock periods |
| ext_sync_i | input | 1 | External frame-sync pin |
| copy_evt_i | input | 1 | Strobe marking a holding-to-shift register copy |
| pulse_o | output | 1 | Periodic frame-sync train |
| txsync_o | output | 1 | Frame sync delivered to the transmitter |

## Verification
The periodic train is swept over every pairing of period 1 to 7 with width 1 to 9, across at least two full periods each. This separates ordinary short pulses, widths equal to or beyond the period (continuous high), and the single-enable period. Some enable strobes are spaced out with idle cycles, which shows that the count follows the strobe and not the system clock. A period reprogrammed in the middle of a frame tells a boundary-applied change apart from an immediate one. Copy events placed before, on and repeatedly ahead of an enable show when the one-shot starts and that repeated events merge; toggling the pin while the internal sources are active shows the bypass.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

    localparam int PER_W_DEF = 12;
    localparam int WID_W_DEF = 8;

    typedef enum logic [1:0] {
        SRC_PIN      = 2'd0,
        SRC_COPY     = 2'd1,
        SRC_PERIODIC = 2'd2
    } sync_src_e;

    function automatic sync_src_e pick_src(input logic internal, input logic periodic);
        if (!internal)
            return SRC_PIN;
        else if (periodic)
            return SRC_PERIODIC;
        else
            return SRC_COPY;
    endfunction

endpackage

// File: rtl/txfs_period_gen.sv
module txfs_period_gen #(
    parameter int PER_W = txfs_pkg::PER_W_DEF,
    parameter int WID_W = txfs_pkg::WID_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [WID_W-1:0] wid_i,
    output logic             pulse_o
);
    localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [WID_W-1:0] wid;
    } frame_cfg_t;

    frame_cfg_t       cfg_q, cfg_nx;
    logic [PER_W-1:0] cnt_q, cnt_nx;
    logic             run_q;
    logic             hi_q, hi_nx;
    logic             wrap;

    // Start of a new frame: after reset, or once the last count is reached.
    always_comb begin
        wrap = !run_q || (cnt_q == cfg_q.per);
        if (wrap) begin
            cnt_nx     = '0;
            cfg_nx.per = per_i;
            cfg_nx.wid = wid_i;
        end else begin
            cnt_nx = cnt_q + PER_W'(1);
            cfg_nx = cfg_q;
        end
        hi_nx = CMP_W'(cnt_nx) <= CMP_W'(cfg_nx.wid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cfg_q <= '0;
            run_q <= 1'b0;
            hi_q  <= 1'b0;
        end else if (tick_i) begin
            cnt_q <= cnt_nx;
            cfg_q <= cfg_nx;
            run_q <= 1'b1;
            hi_q  <= hi_nx;
        end
    end

    assign pulse_o = hi_q;

endmodule

// File: rtl/txfs_copy_shot.sv
module txfs_copy_shot (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic copy_i,
    output logic shot_o
);
    logic pend_q;
    logic shot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            shot_q <= 1'b0;
        end else if (tick_i) begin
            shot_q <= pend_q | copy_i;
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_q | copy_i;
        end
    end

    assign shot_o = shot_q;

endmodule

// File: rtl/txfs_src_mux.sv
module txfs_src_mux
    import txfs_pkg::*;
(
    input  sync_src_e sel_i,
    input  logic      pin_i,
    input  logic      copy_i,
    input  logic      per_i,
    output logic      sync_o
);
    always_comb begin
        unique case (sel_i)
            SRC_COPY:     sync_o = copy_i;
            SRC_PERIODIC: sync_o = per_i;
            default:      sync_o = pin_i;
        endcase
    end

endmodule

// File: rtl/txfs_gen.sv
module txfs_gen
    import txfs_pkg::*;
#(
    parameter int PER_W = PER_W_DEF,
    parameter int WID_W = WID_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             int_sync_en,
    input  logic             periodic_mode,
    input  logic [PER_W-1:0] period_m1,
    input  logic [WID_W-1:0] width_m1,
    input  logic             ext_sync_i,
    input  logic             copy_evt_i,
    output logic             pulse_o,
    output logic             txsync_o
);
    sync_src_e src_sel;
    logic      shot_w;
    logic      per_w;

    assign src_sel = pick_src(int_sync_en, periodic_mode);

    txfs_period_gen #(.PER_W(PER_W), .WID_W(WID_W)) u_per (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .per_i   (period_m1),
        .wid_i   (width_m1),
        .pulse_o (per_w)
    );

    txfs_copy_shot u_shot (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .copy_i (copy_evt_i),
        .shot_o (shot_w)
    );

    txfs_src_mux u_mux (
        .sel_i  (src_sel),
        .pin_i  (ext_sync_i),
        .copy_i (shot_w),
        .per_i  (per_w),
        .sync_o (txsync_o)
    );

    assign pulse_o = per_w;

endmodule

// File: rtl/txfs_gen_chk.sv
module txfs_gen_chk (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic int_sync_en,
    input logic periodic_mode,
    input logic ext_sync_i,
    input logic copy_evt_i,
    input logic shot_w,
    input logic pulse_o,
    input logic txsync_o
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R8
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_low_chk: assert (pulse_o == 1'b0 && shot_w == 1'b0);
        end
    end

    // R1
    pin_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !int_sync_en |-> (txsync_o == ext_sync_i));

    // R3
    periodic_route_chk: assert property (@(posedge clk) disable iff (rst)
        (int_sync_en && periodic_mode) |-> (txsync_o == pulse_o));

    // R7
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(pulse_o));

    // R7
    shot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(shot_w));

    // R2
    copy_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && copy_evt_i) |=> shot_w);

endmodule

bind txfs_gen txfs_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .int_sync_en   (int_sync_en),
    .periodic_mode (periodic_mode),
    .ext_sync_i    (ext_sync_i),
    .copy_evt_i    (copy_evt_i),
    .shot_w        (shot_w),
    .pulse_o       (pulse_o),
    .txsync_o      (txsync_o)
);

// File: tb/sim_txfs_gen.sv
module sim_txfs_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        int_sync_en = 1'b1;
    logic        periodic_mode = 1'b1;
    logic [11:0] period_m1 = '0;
    logic [7:0]  width_m1 = '0;
    logic        ext_sync_i = 1'b0;
    logic        copy_evt_i = 1'b0;
    logic        pulse_o;
    logic        txsync_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    txfs_gen u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .int_sync_en(int_sync_en),
        .periodic_mode(periodic_mode), .period_m1(period_m1), .width_m1(width_m1),
        .ext_sync_i(ext_sync_i), .copy_evt_i(copy_evt_i),
        .pulse_o(pulse_o), .txsync_o(txsync_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick_i = 1'b0; copy_evt_i = 1'b0;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Periodic sweep: R4 R5 R6 R7 R8 R3
        int_sync_en = 1'b1; periodic_mode = 1'b1;
        for (int p = 0; p < 7; p++) begin
            for (int w = 0; w < 9; w++) begin
                period_m1 = 12'(p); width_m1 = 8'(w);
                do_reset();
                chk("R8", pulse_o, 1'b0);
                for (int k = 0; k < 2*(p+1) + 2; k++) begin
                    logic exp;
                    string tag;
                    tick_once();
                    exp = ((k % (p+1)) <= w);
                    if (w >= p)      tag = "R6";
                    else if (k == 0) tag = "R8";
                    else if (k > p)  tag = "R4";
                    else             tag = "R5";
                    chk(tag, pulse_o, exp);
                    chk("R3", txsync_o, exp);
                    if (k % 3 == 1) begin
                        idle(2);
                        chk("R7", pulse_o, exp);
                    end
                end
            end
        end

        // R9: change config in the middle of a period
        period_m1 = 12'd3; width_m1 = 8'd0;
        do_reset();
        tick_once(); chk("R9", pulse_o, 1'b1);
        tick_once(); chk("R9", pulse_o, 1'b0);
        period_m1 = 12'd1; width_m1 = 8'd1;
        tick_once(); chk("R9", pulse_o, 1'b0);
        tick_once(); chk("R9", pulse_o, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick_once(); chk("R9", pulse_o, 1'b1);
        end

        // R1: pin bypass while internal sources are busy
        int_sync_en = 1'b0; period_m1 = 12'd2; width_m1 = 8'd0;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            ext_sync_i = i[0] ^ i[2];
            copy_evt_i = i[1];
            tick_once();
            #1;
            chk("R1", txsync_o, ext_sync_i);
        end
        copy_evt_i = 1'b0;
        ext_sync_i = 1'b1; #1 chk("R1", txsync_o, 1'b1);
        ext_sync_i = 1'b0; #1 chk("R1", txsync_o, 1'b0);

        // R2: copy-triggered one-shot
        int_sync_en = 1'b1; periodic_mode = 1'b0;
        do_reset();
        chk("R8", txsync_o, 1'b0);
        @(negedge clk) copy_evt_i = 1'b1;
        @(negedge clk) copy_evt_i = 1'b0;
        chk("R2", txsync_o, 1'b0);
        tick_once(); chk("R2", txsync_o, 1'b1);
        idle(2);     chk("R7", txsync_o, 1'b1);
        tick_once(); chk("R2", txsync_o, 1'b0);
        // event on the same cycle as an enable
        @(negedge clk) begin copy_evt_i = 1'b1; tick_i = 1'b1; end
        @(negedge clk) begin copy_evt_i = 1'b0; tick_i = 1'b0; end
        chk("R2", txsync_o, 1'b1);
        tick_once(); chk("R2", txsync_o, 1'b0);

        // R10: merged events
        @(negedge clk) copy_evt_i = 1'b1;
        @(negedge clk) copy_evt_i = 1'b0;
        idle(1);
        @(negedge clk) copy_evt_i = 1'b1;
        @(negedge clk) copy_evt_i = 1'b0;
        tick_once(); chk("R10", txsync_o, 1'b1);
        tick_once(); chk("R10", txsync_o, 1'b0);
        tick_once(); chk("R10", txsync_o, 1'b0);

        // R8: reset clears a pending one-shot
        @(negedge clk) copy_evt_i = 1'b1;
        @(negedge clk) copy_evt_i = 1'b0;
        do_reset();
        tick_once(); chk("R8", txsync_o, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule